// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block sits between a byte-wide host bus and three counting channels of an interval timer. The host reaches it through a 2-bit address: addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2, and address 3 is the control port. Bytes written to the control port are decoded as channel set-up words, counter-latch commands or read-back commands. Bytes written to a data port are assembled into 16-bit reload values according to that channel's access mode. Reads of a data port return a pending status byte, a frozen count or the live count, in that order of preference.

Toward the channels the block drives, per channel, the counting mode and BCD flag, a one-cycle load strobe with the assembled 16-bit value, and a one-cycle strobe that marks each count capture. From the channels it takes the live 16-bit counts and the OUT levels. The counting itself lives in the channels and is not part of this block.

Each channel keeps its own byte toggles for reads and writes, its own frozen count and its own status holding register. All of them are replicated per channel, so traffic on one channel never disturbs another.

Top module: `tmr_regif`

## Requirements
- R1: After reset every channel has mode 0, BCD 0 and access mode word (code 3); no load or latch strobe is pending; and both the read and the write toggles point at the low byte.
- R2: A byte written to address 3 with bits [7:6] = n (0..2) and bits [5:4] non-zero sets channel n's access mode from bits [5:4] (1 low byte only, 2 high byte only, 3 low then high), its mode from bits [3:1] and its BCD flag from bit 0. The new mode and BCD appear on the outputs in the next cycle.
- R3: Mode codes 6 and 7 are stored and output as 2 and 3.
- R4: In low-only access, a data write loads {8'h00, byte}. In high-only access, it loads {byte, 8'h00}. The load strobe and value appear in the cycle after the write.
- R5: In word access, the first data write is held as the low byte and gives no load; the second loads {second, first}.
- R6: A control word for a channel returns both of its byte toggles to the low byte.
- R7: Bits [5:4] = 0 with bits [7:6] = n captures channel n's live count, and the capture strobe fires in the next cycle. While a capture is unread, a further capture request is ignored and gives no strobe. The mode, BCD and access mode stay unchanged.
- R8: A frozen count is read as the low byte in low-only access, as the high byte in high-only access, and as low then high in word access. The freeze is released after the last byte.
- R9: With nothing frozen, a data read returns the live low byte in low-only access and the live high byte in high-only access. In word access it alternates low and high, starting at low.
- R10: Bits [7:6] = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 captures the count of each selected channel and bit 4 = 0 captures its status.
- R11: The status byte is {OUT, 1'b0, access[1:0], mode[2:0], BCD}. It is captured only when no status is already pending. A read returns a pending status before any frozen count and clears it.
- R12: A read of address 3 returns 0 and changes no state. When read and write strobes arrive in the same cycle, only the write is taken and rdata is 0. Read data is valid in the cycle of the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 2 | 0..2 channel data port, 3 control port |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte, valid with rd_en |
| ch_live | input | 48 | Live counts, channel n at [16n+15:16n] |
| ch_out | input | 3 | OUT level of each channel |
| ch_mode | output | 9 | Counting mode, channel n at [3n+2:3n] |
| ch_bcd | output | 3 | BCD flag of each channel |
| ch_load | output | 3 | One-cycle reload strobe per channel |
| ch_load_val | output | 48 | Assembled reload value, channel n at [16n+15:16n] |
| ch_latch | output | 3 | One-cycle count-capture strobe per channel |

## Verification
Most faults inside this block are wrong byte toggles or stale holding flags, and they never show on the mode outputs. They show as a wrong byte at the first read after the fault, or as a load that fires one byte early or late. So the bench checks every read byte and every load and capture strobe in the cycle in which it is due. It also treats any strobe nobody asked for as a failure.

A status or freeze flag that stays set after its last byte is caught on the very next read of that channel, which then returns held data instead of live data. An ignored second capture is checked both by the absence of a strobe and by the byte that a later read returns.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } chcfg_t;

    localparam logic [1:0] CTL_ADDR = 2'd3;
    localparam logic [1:0] RB_SEL   = 2'd3;

    function automatic logic [2:0] fold_mode(input logic [2:0] m);
        return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
    endfunction

endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
    import tmr_regif_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic           ctl_we,
    input  logic [7:0]     wdata,
    output chcfg_t         cfg_new,
    output logic [NCH-1:0] cfg_we,
    output logic [NCH-1:0] cnt_req,
    output logic [NCH-1:0] sts_req
);
    logic [1:0] sel;
    acc_e       acc;
    logic       is_rb;

    always_comb begin
        sel   = wdata[7:6];
        acc   = acc_e'(wdata[5:4]);
        is_rb = (sel == RB_SEL);
        cfg_new.acc  = acc;
        cfg_new.mode = fold_mode(wdata[3:1]);
        cfg_new.bcd  = wdata[0];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        logic hit;
        logic rb_hit;
        assign hit    = ctl_we && !is_rb && (sel == 2'(i));
        assign rb_hit = ctl_we && is_rb && wdata[i+1];
        assign cfg_we[i]  = hit && (acc != ACC_LATCH);
        assign cnt_req[i] = (hit && (acc == ACC_LATCH)) || (rb_hit && !wdata[5]);
        assign sts_req[i] = rb_hit && !wdata[4];
    end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_regif_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  chcfg_t          cfg_new,
    input  logic            cnt_req,
    input  logic            sts_req,
    input  logic            data_we,
    input  logic            data_re,
    input  logic [BW-1:0]   wbyte,
    input  logic [2*BW-1:0] live,
    input  logic            out_lvl,
    output chcfg_t          cfg,
    output logic [BW-1:0]   rbyte,
    output logic            load,
    output logic [2*BW-1:0] load_val,
    output logic            latch
);
    localparam int CW = 2 * BW;

    typedef struct packed {
        chcfg_t        cfg;
        logic          wr_hi;
        logic          rd_hi;
        logic [BW-1:0] lo_byte;
        logic          sts_pend;
        logic [7:0]    sts;
        acc_e          held;
        logic [CW-1:0] held_val;
        logic          load;
        logic [CW-1:0] load_val;
        logic          latch;
    } st_t;

    st_t st_d, st_q;
    logic [BW-1:0] rd_byte;

    always_comb begin
        st_d       = st_q;
        st_d.load  = 1'b0;
        st_d.latch = 1'b0;

        if (st_q.sts_pend) begin
            rd_byte = BW'(st_q.sts);
        end else if (st_q.held != ACC_LATCH) begin
            rd_byte = (st_q.held == ACC_HI) ? st_q.held_val[CW-1:BW] : st_q.held_val[BW-1:0];
        end else begin
            case (st_q.cfg.acc)
                ACC_HI:   rd_byte = live[CW-1:BW];
                ACC_WORD: rd_byte = st_q.rd_hi ? live[CW-1:BW] : live[BW-1:0];
                default:  rd_byte = live[BW-1:0];
            endcase
        end

        if (cfg_we) begin
            st_d.cfg   = cfg_new;
            st_d.wr_hi = 1'b0;
            st_d.rd_hi = 1'b0;
        end

        if (cnt_req && (st_q.held == ACC_LATCH)) begin
            st_d.held     = st_q.cfg.acc;
            st_d.held_val = live;
            st_d.latch    = 1'b1;
        end

        if (sts_req && !st_q.sts_pend) begin
            st_d.sts_pend = 1'b1;
            st_d.sts      = {out_lvl, 1'b0, st_q.cfg.acc, st_q.cfg.mode, st_q.cfg.bcd};
        end

        if (data_we) begin
            case (st_q.cfg.acc)
                ACC_HI: begin
                    st_d.load     = 1'b1;
                    st_d.load_val = {wbyte, BW'(0)};
                end
                ACC_WORD: begin
                    if (st_q.wr_hi) begin
                        st_d.load     = 1'b1;
                        st_d.load_val = {wbyte, st_q.lo_byte};
                        st_d.wr_hi    = 1'b0;
                    end else begin
                        st_d.lo_byte = wbyte;
                        st_d.wr_hi   = 1'b1;
                    end
                end
                default: begin
                    st_d.load     = 1'b1;
                    st_d.load_val = {BW'(0), wbyte};
                end
            endcase
        end

        if (data_re) begin
            if (st_q.sts_pend) begin
                st_d.sts_pend = 1'b0;
            end else if (st_q.held != ACC_LATCH) begin
                st_d.held = (st_q.held == ACC_WORD) ? ACC_HI : ACC_LATCH;
            end else if (st_q.cfg.acc == ACC_WORD) begin
                st_d.rd_hi = !st_q.rd_hi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cfg.acc  <= ACC_WORD;
            st_q.held     <= ACC_LATCH;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg      = st_q.cfg;
    assign rbyte    = rd_byte;
    assign load     = st_q.load;
    assign load_val = st_q.load_val;
    assign latch    = st_q.latch;

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_regif_pkg::*;
#(
    parameter int NCH = 3,
    parameter int BW  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [1:0]          addr,
    input  logic [BW-1:0]       wdata,
    output logic [BW-1:0]       rdata,
    input  logic [NCH*2*BW-1:0] ch_live,
    input  logic [NCH-1:0]      ch_out,
    output logic [NCH*3-1:0]    ch_mode,
    output logic [NCH-1:0]      ch_bcd,
    output logic [NCH-1:0]      ch_load,
    output logic [NCH*2*BW-1:0] ch_load_val,
    output logic [NCH-1:0]      ch_latch
);
    localparam int CW = 2 * BW;

    logic           wr_take;
    logic           rd_take;
    logic           ctl_we;
    chcfg_t         cfg_new;
    logic [NCH-1:0] cfg_we;
    logic [NCH-1:0] cnt_req;
    logic [NCH-1:0] sts_req;
    logic [BW-1:0]  ch_rd [NCH];

    assign wr_take = wr_en;
    assign rd_take = rd_en && !wr_en;
    assign ctl_we  = wr_take && (addr == CTL_ADDR);

    tmr_ctl_decode #(.NCH(NCH)) u_dec (
        .ctl_we  (ctl_we),
        .wdata   (wdata[7:0]),
        .cfg_new (cfg_new),
        .cfg_we  (cfg_we),
        .cnt_req (cnt_req),
        .sts_req (sts_req)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chcfg_t cfg;
        tmr_chan_regs #(.BW(BW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we[i]),
            .cfg_new  (cfg_new),
            .cnt_req  (cnt_req[i]),
            .sts_req  (sts_req[i]),
            .data_we  (wr_take && (addr == 2'(i))),
            .data_re  (rd_take && (addr == 2'(i))),
            .wbyte    (wdata),
            .live     (ch_live[i*CW +: CW]),
            .out_lvl  (ch_out[i]),
            .cfg      (cfg),
            .rbyte    (ch_rd[i]),
            .load     (ch_load[i]),
            .load_val (ch_load_val[i*CW +: CW]),
            .latch    (ch_latch[i])
        );
        assign ch_mode[i*3 +: 3] = cfg.mode;
        assign ch_bcd[i]         = cfg.bcd;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_take && (addr == 2'(i))) rdata = ch_rd[i];
        end
    end

endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk #(
    parameter int NCH = 3,
    parameter int BW  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [BW-1:0]    wdata,
    input logic [NCH*3-1:0] ch_mode,
    input logic [NCH-1:0]   ch_load,
    input logic [NCH-1:0]   ch_latch
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R4
        load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_load[i] |-> $past(wr_en && (addr == 2'(i))));

        // R7
        latch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_latch[i] |-> $past(wr_en && (addr == 2'd3)));

        // R12
        one_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(ch_load[i] && ch_latch[i]));

        // R3
        mode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_mode[i*3 +: 3] <= 3'd5);

        // R2
        mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == 2'd3 && wdata[7:6] == 2'(i) && wdata[5:4] != 2'd0
             && wdata[3:2] != 2'b11)
            |=> ch_mode[i*3 +: 3] == $past(wdata[3:1]));

        // R3
        mode_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == 2'd3 && wdata[7:6] == 2'(i) && wdata[5:4] != 2'd0
             && wdata[3:2] == 2'b11)
            |=> ch_mode[i*3 +: 3] == {1'b0, $past(wdata[2:1])});
    end
endmodule

bind tmr_regif tmr_regif_chk #(.NCH(NCH), .BW(BW)) u_chk (.*);

// File: tb/tb_tmr_regif.sv
module tb_tmr_regif;
    localparam int TCK = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] live0 = 16'h1234, live1 = 16'hC3A5, live2 = 16'hBEEF;
    logic [2:0]  ch_out = '0;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;
    logic [2:0]  ch_load;
    logic [47:0] ch_load_val;
    logic [2:0]  ch_latch;

    tmr_regif dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ch_live({live2, live1, live0}),
        .ch_out(ch_out), .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_load(ch_load),
        .ch_load_val(ch_load_val), .ch_latch(ch_latch)
    );

    always #(TCK/2) clk = ~clk;

    localparam int K_RD = 0, K_LD = 1, K_LA = 2, K_MD = 3;
    typedef struct {
        int    kind;
        int    ch;
        int    val;
        int    due;
        string tag;
    } item_t;

    item_t q[$];
    item_t it;
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    logic [2:0] seen_ld, seen_la;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int kind, input int ch, input int val, input int due, input string tag);
        item_t x;
        x.kind = kind; x.ch = ch; x.val = val; x.due = due; x.tag = tag;
        q.push_back(x);
    endtask

    // monitor: samples a quarter period after the falling edge
    always @(negedge clk) begin
        #(TCK/4);
        if (rst_n) begin
            seen_ld = '0;
            seen_la = '0;
            while (q.size() > 0 && q[0].due <= cyc) begin
                it = q.pop_front();
                case (it.kind)
                    K_RD: chk(rdata == it.val[7:0], it.tag, rdata, it.val);
                    K_LD: begin
                        seen_ld[it.ch] = 1'b1;
                        chk(ch_load[it.ch] && ch_load_val[it.ch*16 +: 16] == it.val[15:0], it.tag,
                            ch_load[it.ch] ? int'(ch_load_val[it.ch*16 +: 16]) : -1, it.val);
                    end
                    K_LA: begin
                        seen_la[it.ch] = 1'b1;
                        chk(ch_latch[it.ch], it.tag, ch_latch[it.ch], 1);
                    end
                    default: chk({ch_bcd[it.ch], ch_mode[it.ch*3 +: 3]} == it.val[3:0], it.tag,
                                 {ch_bcd[it.ch], ch_mode[it.ch*3 +: 3]}, it.val);
                endcase
            end
            for (int c = 0; c < 3; c++) begin
                if (ch_load[c] && !seen_ld[c]) chk(1'b0, "R5 unexpected load", c, -1);
                if (ch_latch[c] && !seen_la[c]) chk(1'b0, "R7 unexpected latch", c, -1);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_ld(input logic [1:0] a, input logic [7:0] d, input int v, input string tag);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        push(K_LD, a, v, cyc + 1, tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_md(input logic [7:0] d, input int ch, input int v, input string tag);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd3; wdata = d;
        push(K_MD, ch, v, cyc + 1, tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_la(input logic [7:0] d, input logic [2:0] chs, input string tag);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd3; wdata = d;
        for (int c = 0; c < 3; c++) if (chs[c]) push(K_LA, c, 1, cyc + 1, tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        push(K_RD, a, exp, cyc, tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset configuration and toggles
        for (int c = 0; c < 3; c++) push(K_MD, c, 0, cyc, "R1 reset mode/bcd");
        rd(2'd0, 8'h34, "R1 R9 word low first");
        rd(2'd0, 8'h12, "R9 word high");
        rd(2'd0, 8'h34, "R9 word wraps to low");
        // R2 / R4: low-only access
        wr_md(8'h15, 0, 4'hA, "R2 ch0 mode2 bcd1");
        wr_ld(2'd0, 8'hAB, 16'h00AB, "R4 low-only load");
        rd(2'd0, 8'h34, "R9 low-only live");
        rd(2'd0, 8'h34, "R9 low-only no toggle");
        // R3 / R4: high-only access, alias 7 -> 3
        wr_md(8'h6E, 1, 4'h3, "R3 mode7 folds to 3");
        wr_ld(2'd1, 8'h5C, 16'h5C00, "R4 high-only load");
        rd(2'd1, 8'hC3, "R9 high-only live");
        // R3 / R5: word access, alias 6 -> 2
        wr_md(8'hBC, 2, 4'h2, "R3 mode6 folds to 2");
        wr(2'd2, 8'h34);
        wr_ld(2'd2, 8'h12, 16'h1234, "R5 word load");
        // R6: control word resets both toggles
        wr(2'd2, 8'h77);
        wr_md(8'hB0, 2, 4'h0, "R6 ctl mode0");
        wr(2'd2, 8'h11);
        wr_ld(2'd2, 8'h22, 16'h2211, "R6 write toggle reset");
        rd(2'd2, 8'hEF, "R9 ch2 low");
        wr_md(8'hB0, 2, 4'h0, "R6 ctl again");
        rd(2'd2, 8'hEF, "R6 read toggle reset");
        rd(2'd2, 8'hBE, "R9 ch2 high");
        // R7 / R8: counter latch, low-only
        wr_la(8'h00, 3'b001, "R7 latch ch0 strobe");
        live0 = 16'h5678;
        wr(2'd3, 8'h00);
        rd(2'd0, 8'h34, "R7 R8 frozen low, second latch ignored");
        rd(2'd0, 8'h78, "R8 released to live");
        push(K_MD, 0, 4'hA, cyc, "R7 fields unchanged");
        // R8: word latch
        wr_la(8'h80, 3'b100, "R7 latch ch2 strobe");
        live2 = 16'h0001;
        rd(2'd2, 8'hEF, "R8 word frozen low");
        rd(2'd2, 8'hBE, "R8 word frozen high");
        rd(2'd2, 8'h01, "R8 word released");
        // R8: high-only latch
        wr_la(8'h40, 3'b010, "R7 latch ch1 strobe");
        live1 = 16'h0F0F;
        rd(2'd1, 8'hC3, "R8 high-only frozen");
        rd(2'd1, 8'h0F, "R8 high-only released");
        // R10 / R11: read-back status only
        ch_out = 3'b010;
        wr(2'd3, 8'hE4);
        rd(2'd1, 8'hA6, "R11 status byte ch1");
        rd(2'd1, 8'h0F, "R10 no count captured");
        // R10 / R11: read-back count+status on ch0 and ch2
        ch_out = 3'b000;
        wr_la(8'hCA, 3'b101, "R10 readback count strobe");
        live0 = 16'h9ABC;
        live2 = 16'h4455;
        ch_out = 3'b001;
        wr(2'd3, 8'hE2);
        rd(2'd0, 8'h15, "R11 status first, second ignored");
        rd(2'd0, 8'h78, "R10 R11 frozen after status");
        rd(2'd0, 8'hBC, "R10 live after release");
        rd(2'd2, 8'h30, "R11 status ch2");
        rd(2'd2, 8'h01, "R10 ch2 frozen low");
        rd(2'd2, 8'h00, "R10 ch2 frozen high");
        rd(2'd2, 8'h44, "R9 ch2 live toggle kept");
        // R12: control read and write-priority
        wr(2'd3, 8'hE4);
        rd(2'd3, 8'h00, "R12 control read is 0");
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 2'd1; wdata = 8'h33;
        push(K_RD, 1, 8'h00, cyc, "R12 rdata 0 during write");
        push(K_LD, 1, 16'h3300, cyc + 1, "R12 write taken");
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        rd(2'd1, 8'h26, "R12 status survived");
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R12 scoreboard drained", q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule